// File: doc/BRIEF.md
# Beam-Position Interrupt and Status Controller

This block sits on a byte-wide CPU register bus. It turns the position of the video beam into processor interrupts. It watches the horizontal and vertical beam counters and four timing strobes: dot advance, start of line, start of horizontal blanking and start of vertical blanking. From these it raises a timer IRQ at a programmed dot and/or line. It also raises a delayed NMI at the start of vertical blanking. Each timer event pulses a strobe that tells the video generator to capture its beam counters.

Software sees the block through these registers:
- an interrupt-enable byte;
- two 9-bit compare values, each split over a low and a high register;
- an NMI flag byte that clears itself when read;
- a timer flag byte that clears when read or written;
- a read-only blanking/busy status byte;
- a general-purpose output byte that reads back.

A rising edge on bit 7 of the general-purpose byte also pulses the counter-capture strobe. A "controller auto-read done" pulse clears the busy bit.

Three state machines do the work:
- The timer machine has states `IRQ_CLEAR` and `IRQ_ACTIVE`. A compare event moves it to `IRQ_ACTIVE`. A flag access or a disabling enable write returns it to `IRQ_CLEAR`, and an event in the same cycle wins.
- The NMI machine has states `NMI_IDLE`, `NMI_WAIT` and `NMI_FIRE`. Start of vertical blanking with NMI enabled moves `NMI_IDLE`/`NMI_FIRE` to `NMI_WAIT`. A countdown reaching zero moves `NMI_WAIT` to `NMI_FIRE`. `NMI_FIRE` always leaves after one cycle.
- The compare mode is decoded from enable bits 5:4 as `MODE_OFF`, `MODE_H`, `MODE_V` or `MODE_HV`.

Top module: `vid_irq_ctrl`

## Requirements
- R1: Address map:
  - 0 enable;
  - 1/2 horizontal compare low byte / high bit;
  - 3/4 vertical compare low byte / high bit;
  - 5 NMI flag;
  - 6 timer flag;
  - 7 status;
  - 8 general-purpose byte;
  - unmapped addresses read 0.
  
  After reset, the registers read: enable 0x00, compare low bytes 0xFF, compare high bits 0x01, general-purpose 0xFF, status 0x00, timer flag 0x00, NMI flag 0x02. `nmi`, `irq` and `latch_strobe` are low.
- R2: With enable bits 5:4 = 10, a `line_start` while `v_count` equals the vertical compare is a timer event. `dot_tick` alone never is. An event sets the timer flag (bit 7) and `irq`, and pulses `latch_strobe` for one cycle, all in the cycle after the event.
- R3: With bits 5:4 = 01, a `dot_tick` while `h_count` equals the 9-bit horizontal compare is a timer event on any line.
- R4: With bits 5:4 = 11, an event needs a `dot_tick` with both `h_count` and `v_count` matching their compares.
- R5: With bits 5:4 = 00, no strobe produces a timer event.
- R6: Reading address 6 returns the flag in bit 7 and zeros below it. A read or a write there clears the flag and `irq` from the next cycle, unless a new event arrives in the same cycle.
- R7: Writing the enable register with bits 5:4 = 00 clears a pending timer flag and `irq`.
- R8: `vblank_start` sets status bit 7 (vblank), status bit 0 (busy) and the NMI flag. If enable bit 7 is set, `nmi` is high for exactly one cycle, 12 cycles after the cycle in which `vblank_start` was sampled. Otherwise `nmi` stays low.
- R9: Reading address 5 returns the NMI flag in bit 7, zeros in bits 6:4 and the version value 2 in bits 3:0. The read clears the flag.
- R10: `line_start` with `v_count` = 0 clears the vblank status bit and the NMI flag. A `line_start` on any other line leaves them alone.
- R11:
  - status bit 6 is set by `hblank_start` and cleared by `line_start`;
  - `autoread_done` clears status bit 0;
  - status bits 5:1 read 0.
- R12:
  - a write to address 8 that takes bit 7 from 0 to 1 pulses `latch_strobe` in the next cycle;
  - other writes there do not pulse it;
  - the byte reads back as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| h_count | input | CNT_W | Horizontal beam position |
| v_count | input | CNT_W | Vertical beam position |
| dot_tick | input | 1 | Beam advanced one dot |
| hblank_start | input | 1 | Horizontal blanking begins |
| line_start | input | 1 | New line begins (v_count already holds it) |
| vblank_start | input | 1 | Vertical blanking begins |
| autoread_done | input | 1 | Controller auto-read finished |
| nmi | output | 1 | One-cycle NMI pulse |
| irq | output | 1 | Timer IRQ level |
| latch_strobe | output | 1 | Beam-counter capture pulse |

## Verification
Timing by stimulus:
- Read data is combinational, so the bench samples it 1 ns after driving the address. It checks the clear-on-read effect one cycle later.
- Timer events, bus writes and beam strobes are registered once. Their effects on `irq`, `latch_strobe` and the status bits are checked at the first falling edge after the sampling edge. The strobe's return to zero is checked one falling edge later.
- `nmi` is checked at every falling edge from 0 to 13 after the edge that sampled `vblank_start`. It must be high only at edge 12.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_IEN  = 4'd0,
        RA_HTL  = 4'd1,
        RA_HTH  = 4'd2,
        RA_VTL  = 4'd3,
        RA_VTH  = 4'd4,
        RA_NMIF = 4'd5,
        RA_TMRF = 4'd6,
        RA_STAT = 4'd7,
        RA_GPIO = 4'd8
    } reg_addr_e;

    localparam int IEN_NMI_BIT  = 7;
    localparam int IEN_VIRQ_BIT = 5;
    localparam int IEN_HIRQ_BIT = 4;
    localparam int FLAG_BIT     = 7;
    localparam logic [3:0] CHIP_VERSION = 4'h2;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_H   = 2'b01,
        MODE_V   = 2'b10,
        MODE_HV  = 2'b11
    } irq_mode_e;

    typedef enum logic {
        IRQ_CLEAR  = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        NMI_IDLE = 2'd0,
        NMI_WAIT = 2'd1,
        NMI_FIRE = 2'd2
    } nmi_state_e;

endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 tmr_flag,
    input  logic                 nmi_flag,
    input  logic                 stat_vblank,
    input  logic                 stat_hblank,
    input  logic                 stat_busy,
    output logic                 nmi_en,
    output irq_mode_e            irq_mode,
    output logic [CNT_W-1:0]     htime,
    output logic [CNT_W-1:0]     vtime,
    output logic                 tmr_clr,
    output logic                 nmif_read,
    output logic                 gpio_rise
);

    localparam int HI_W = CNT_W - 8;

    logic [DATA_W-1:0] ien_q;
    logic [DATA_W-1:0] gpio_q;
    logic [CNT_W-1:0]  htime_q;
    logic [CNT_W-1:0]  vtime_q;
    logic              wr;
    logic              rd;

    assign wr = bus_sel &&  bus_we;
    assign rd = bus_sel && !bus_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q   <= '0;
            gpio_q  <= '1;
            htime_q <= '1;
            vtime_q <= '1;
        end else if (wr) begin
            case (bus_addr)
                RA_IEN:  ien_q <= bus_wdata;
                RA_HTL:  htime_q[7:0] <= bus_wdata;
                RA_HTH:  htime_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
                RA_VTL:  vtime_q[7:0] <= bus_wdata;
                RA_VTH:  vtime_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
                RA_GPIO: gpio_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign nmi_en   = ien_q[IEN_NMI_BIT];
    assign irq_mode = irq_mode_e'({ien_q[IEN_VIRQ_BIT], ien_q[IEN_HIRQ_BIT]});
    assign htime    = htime_q;
    assign vtime    = vtime_q;

    // timer flag is cleared by any access to it, or by an enable write
    // that turns off both compare sources
    assign tmr_clr = (bus_sel && bus_addr == RA_TMRF)
                   || (wr && bus_addr == RA_IEN
                       && bus_wdata[IEN_VIRQ_BIT] == 1'b0
                       && bus_wdata[IEN_HIRQ_BIT] == 1'b0);
    assign nmif_read = rd && bus_addr == RA_NMIF;
    assign gpio_rise = wr && bus_addr == RA_GPIO
                     && !gpio_q[FLAG_BIT] && bus_wdata[FLAG_BIT];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_IEN:  bus_rdata = ien_q;
            RA_HTL:  bus_rdata = htime_q[7:0];
            RA_HTH:  bus_rdata[HI_W-1:0] = htime_q[CNT_W-1:8];
            RA_VTL:  bus_rdata = vtime_q[7:0];
            RA_VTH:  bus_rdata[HI_W-1:0] = vtime_q[CNT_W-1:8];
            RA_NMIF: bus_rdata = {nmi_flag, 3'b000, CHIP_VERSION};
            RA_TMRF: bus_rdata[FLAG_BIT] = tmr_flag;
            RA_STAT: bus_rdata = {stat_vblank, stat_hblank, 5'b00000, stat_busy};
            RA_GPIO: bus_rdata = gpio_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vic_irq_gen.sv
module vic_irq_gen
    import vic_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irq_mode_e        irq_mode,
    input  logic [CNT_W-1:0] htime,
    input  logic [CNT_W-1:0] vtime,
    input  logic [CNT_W-1:0] h_count,
    input  logic [CNT_W-1:0] v_count,
    input  logic             dot_tick,
    input  logic             line_start,
    input  logic             tmr_clr,
    output logic             irq_event,
    output logic             irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       h_hit;
    logic       v_hit;

    assign h_hit = (h_count == htime);
    assign v_hit = (v_count == vtime);

    always_comb begin
        irq_event = 1'b0;
        unique case (irq_mode)
            MODE_OFF: irq_event = 1'b0;
            MODE_H:   irq_event = dot_tick && h_hit;
            MODE_V:   irq_event = line_start && v_hit;
            MODE_HV:  irq_event = dot_tick && h_hit && v_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_CLEAR:  if (irq_event) state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!irq_event && tmr_clr) state_d = IRQ_CLEAR;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/vic_nmi_delay.sv
module vic_nmi_delay
    import vic_pkg::*;
#(
    parameter int NMI_DELAY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic nmi
);

    localparam int CW = (NMI_DELAY > 2) ? $clog2(NMI_DELAY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(NMI_DELAY - 1);

    nmi_state_e     state_q;
    nmi_state_e     state_d;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NMI_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != NMI_WAIT && start) cnt_q <= LOAD;
            else if (state_q == NMI_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE: if (start) state_d = NMI_WAIT;
            NMI_WAIT: if (cnt_q == '0) state_d = NMI_FIRE;
            NMI_FIRE: state_d = start ? NMI_WAIT : NMI_IDLE;
            default:  state_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        nmi = (state_q == NMI_FIRE);
    end

endmodule

// File: rtl/vic_status.sv
module vic_status (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank_start,
    input  logic hblank_start,
    input  logic line_start,
    input  logic first_line,
    input  logic autoread_done,
    input  logic nmif_read,
    output logic nmi_flag,
    output logic vblank,
    output logic hblank,
    output logic busy
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_flag <= 1'b0;
            vblank   <= 1'b0;
            hblank   <= 1'b0;
            busy     <= 1'b0;
        end else begin
            // setting events take priority over clearing ones
            if (vblank_start)                         nmi_flag <= 1'b1;
            else if (nmif_read || (line_start && first_line)) nmi_flag <= 1'b0;

            if (vblank_start)                         vblank <= 1'b1;
            else if (line_start && first_line)        vblank <= 1'b0;

            if (hblank_start)                         hblank <= 1'b1;
            else if (line_start)                      hblank <= 1'b0;

            if (vblank_start)                         busy <= 1'b1;
            else if (autoread_done)                   busy <= 1'b0;
        end
    end

endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
    import vic_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int NMI_DELAY = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [CNT_W-1:0]  h_count,
    input  logic [CNT_W-1:0]  v_count,
    input  logic              dot_tick,
    input  logic              hblank_start,
    input  logic              line_start,
    input  logic              vblank_start,
    input  logic              autoread_done,
    output logic              nmi,
    output logic              irq,
    output logic              latch_strobe
);

    logic             nmi_en;
    irq_mode_e        irq_mode;
    logic [CNT_W-1:0] htime;
    logic [CNT_W-1:0] vtime;
    logic             tmr_clr;
    logic             nmif_read;
    logic             gpio_rise;
    logic             irq_event;
    logic             nmi_flag;
    logic             st_vblank;
    logic             st_hblank;
    logic             st_busy;
    logic             strobe_q;

    vic_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tmr_flag    (irq),
        .nmi_flag    (nmi_flag),
        .stat_vblank (st_vblank),
        .stat_hblank (st_hblank),
        .stat_busy   (st_busy),
        .nmi_en      (nmi_en),
        .irq_mode    (irq_mode),
        .htime       (htime),
        .vtime       (vtime),
        .tmr_clr     (tmr_clr),
        .nmif_read   (nmif_read),
        .gpio_rise   (gpio_rise)
    );

    vic_irq_gen #(.CNT_W(CNT_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_mode   (irq_mode),
        .htime      (htime),
        .vtime      (vtime),
        .h_count    (h_count),
        .v_count    (v_count),
        .dot_tick   (dot_tick),
        .line_start (line_start),
        .tmr_clr    (tmr_clr),
        .irq_event  (irq_event),
        .irq        (irq)
    );

    vic_nmi_delay #(.NMI_DELAY(NMI_DELAY)) u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .start (vblank_start && nmi_en),
        .nmi   (nmi)
    );

    vic_status u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .vblank_start  (vblank_start),
        .hblank_start  (hblank_start),
        .line_start    (line_start),
        .first_line    (v_count == '0),
        .autoread_done (autoread_done),
        .nmif_read     (nmif_read),
        .nmi_flag      (nmi_flag),
        .vblank        (st_vblank),
        .hblank        (st_hblank),
        .busy          (st_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= irq_event || gpio_rise;
    end

    assign latch_strobe = strobe_q;

endmodule

// File: rtl/vid_irq_ctrl_chk.sv
module vid_irq_ctrl_chk
    import vic_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [3:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic             dot_tick,
    input logic             line_start,
    input logic             nmi,
    input logic             irq
);

    logic quiet;
    assign quiet = !dot_tick && !line_start;

    AST_IRQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && quiet) |=> !irq);  // R2

    AST_TMR_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == RA_TMRF && quiet) |=> !irq);  // R6

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == RA_IEN && bus_wdata[5:4] == 2'b00 && quiet)
        |=> !irq);  // R7

    AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi);  // R8

    AST_NMIF_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == RA_NMIF) |-> bus_rdata[6:0] == 7'h02);  // R9

    AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == RA_STAT) |-> bus_rdata[5:1] == 5'b0);  // R11

    AST_TMRF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == RA_TMRF) |-> bus_rdata[6:0] == 7'b0);  // R6

endmodule

bind vid_irq_ctrl vid_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dot_tick   (dot_tick),
    .line_start (line_start),
    .nmi        (nmi),
    .irq        (irq)
);

// File: tb/vid_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vid_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [8:0] h_count = '0;
    logic [8:0] v_count = '0;
    logic       dot_tick = 1'b0;
    logic       hblank_start = 1'b0;
    logic       line_start = 1'b0;
    logic       vblank_start = 1'b0;
    logic       autoread_done = 1'b0;
    logic       nmi;
    logic       irq;
    logic       latch_strobe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vid_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .h_count(h_count), .v_count(v_count), .dot_tick(dot_tick),
        .hblank_start(hblank_start), .line_start(line_start),
        .vblank_start(vblank_start), .autoread_done(autoread_done),
        .nmi(nmi), .irq(irq), .latch_strobe(latch_strobe)
    );

    localparam logic [3:0] A_IEN = 4'd0, A_HTL = 4'd1, A_HTH = 4'd2, A_VTL = 4'd3,
                           A_VTH = 4'd4, A_NMIF = 4'd5, A_TMRF = 4'd6,
                           A_STAT = 4'd7, A_GPIO = 4'd8;

    typedef struct packed {
        logic [1:0] mode;
        logic [8:0] ht;
        logic [8:0] vt;
        logic [8:0] h;
        logic [8:0] v;
        logic       use_line;
        logic       fire;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 9'h1FF, 9'h005, 9'h000, 9'h005, 1'b1, 1'b1},
        '{2'b10, 9'h1FF, 9'h005, 9'h000, 9'h006, 1'b1, 1'b0},
        '{2'b10, 9'h1FF, 9'h005, 9'h000, 9'h005, 1'b0, 1'b0},
        '{2'b01, 9'h064, 9'h1FF, 9'h064, 9'h021, 1'b0, 1'b1},
        '{2'b01, 9'h064, 9'h1FF, 9'h065, 9'h021, 1'b0, 1'b0},
        '{2'b01, 9'h150, 9'h1FF, 9'h150, 9'h002, 1'b0, 1'b1},
        '{2'b11, 9'h014, 9'h007, 9'h014, 9'h007, 1'b0, 1'b1},
        '{2'b11, 9'h014, 9'h007, 9'h014, 9'h008, 1'b0, 1'b0},
        '{2'b00, 9'h014, 9'h007, 9'h014, 9'h007, 1'b0, 1'b0}
    };

    function automatic string mode_req(logic [1:0] m);
        case (m)
            2'b10:   return "R2";
            2'b01:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic pulse_line(logic [8:0] v);
        v_count = v; line_start = 1'b1;
        tick();
        line_start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1", "irq", {7'b0, irq}, 8'h00);
        chk("R1", "nmi", {7'b0, nmi}, 8'h00);
        chk("R1", "strobe", {7'b0, latch_strobe}, 8'h00);
        bus_read(A_IEN, rd);  chk("R1", "enable", rd, 8'h00);
        bus_read(A_HTL, rd);  chk("R1", "htime lo", rd, 8'hFF);
        bus_read(A_HTH, rd);  chk("R1", "htime hi", rd, 8'h01);
        bus_read(A_VTL, rd);  chk("R1", "vtime lo", rd, 8'hFF);
        bus_read(A_VTH, rd);  chk("R1", "vtime hi", rd, 8'h01);
        bus_read(A_GPIO, rd); chk("R1", "gpio", rd, 8'hFF);
        bus_read(A_STAT, rd); chk("R1", "status", rd, 8'h00);
        bus_read(A_TMRF, rd); chk("R1", "timer flag", rd, 8'h00);
        bus_read(A_NMIF, rd); chk("R1", "nmi flag", rd, 8'h02);
        bus_read(4'd12, rd);  chk("R1", "unmapped", rd, 8'h00);

        // compare-mode vector table: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            vec_t vv;
            string rq;
            vv = VECS[i];
            rq = mode_req(vv.mode);
            bus_write(A_IEN, {2'b00, vv.mode, 4'b0000});
            bus_write(A_HTL, vv.ht[7:0]);
            bus_write(A_HTH, {7'b0, vv.ht[8]});
            bus_write(A_VTL, vv.vt[7:0]);
            bus_write(A_VTH, {7'b0, vv.vt[8]});
            bus_write(A_TMRF, 8'h00);
            h_count = vv.h; v_count = vv.v;
            if (vv.use_line) line_start = 1'b1; else dot_tick = 1'b1;
            tick();
            line_start = 1'b0; dot_tick = 1'b0;
            chk(rq, $sformatf("vec%0d irq", i), {7'b0, irq}, {7'b0, vv.fire});
            chk(rq, $sformatf("vec%0d strobe", i), {7'b0, latch_strobe}, {7'b0, vv.fire});
            tick();
            chk(rq, $sformatf("vec%0d strobe drop", i), {7'b0, latch_strobe}, 8'h00);
            bus_read(A_TMRF, rd);
            chk(rq, $sformatf("vec%0d flag", i), rd, vv.fire ? 8'h80 : 8'h00);
            chk("R6", $sformatf("vec%0d irq after read", i), {7'b0, irq}, 8'h00);
        end

        // R5: line strobe with both enables off
        bus_write(A_IEN, 8'h00);
        bus_write(A_VTL, 8'h09); bus_write(A_VTH, 8'h00);
        pulse_line(9'd9);
        chk("R5", "line with enables off", {7'b0, irq}, 8'h00);

        // R6: write to timer flag clears
        bus_write(A_IEN, 8'h20);
        pulse_line(9'd9);
        chk("R6", "irq set", {7'b0, irq}, 8'h01);
        bus_write(A_TMRF, 8'h55);
        chk("R6", "irq after write", {7'b0, irq}, 8'h00);

        // R7: disabling enable write clears
        bus_write(A_IEN, 8'h10);
        bus_write(A_HTL, 8'h33); bus_write(A_HTH, 8'h00);
        h_count = 9'h033; dot_tick = 1'b1; tick(); dot_tick = 1'b0;
        chk("R7", "irq set", {7'b0, irq}, 8'h01);
        bus_write(A_IEN, 8'h00);
        chk("R7", "irq after disable", {7'b0, irq}, 8'h00);
        bus_read(A_TMRF, rd); chk("R7", "flag after disable", rd, 8'h00);

        // R8: delayed NMI
        bus_write(A_IEN, 8'h81);
        vblank_start = 1'b1; tick(); vblank_start = 1'b0;
        chk("R8", "nmi cycle 0", {7'b0, nmi}, 8'h00);
        for (int k = 1; k <= 13; k++) begin
            tick();
            chk("R8", $sformatf("nmi cycle %0d", k), {7'b0, nmi}, (k == 12) ? 8'h01 : 8'h00);
        end
        bus_read(A_STAT, rd); chk("R8", "status after vblank", rd, 8'h81);

        // R9: NMI flag register
        bus_read(A_NMIF, rd); chk("R9", "nmi flag set", rd, 8'h82);
        bus_read(A_NMIF, rd); chk("R9", "nmi flag cleared", rd, 8'h02);

        // R8: NMI disabled
        bus_write(A_IEN, 8'h00);
        vblank_start = 1'b1; tick(); vblank_start = 1'b0;
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 20; k++) begin
                tick();
                if (nmi) seen = 1'b1;
            end
            chk("R8", "no nmi when disabled", {7'b0, seen}, 8'h00);
        end

        // R10: first line clears vblank and NMI flag
        pulse_line(9'd3);
        bus_read(A_STAT, rd); chk("R10", "status mid-line", rd, 8'h81);
        pulse_line(9'd0);
        bus_read(A_STAT, rd); chk("R10", "status line 0", rd, 8'h01);
        bus_read(A_NMIF, rd); chk("R10", "nmi flag line 0", rd, 8'h02);

        // R11: hblank bit and busy bit
        hblank_start = 1'b1; tick(); hblank_start = 1'b0;
        bus_read(A_STAT, rd); chk("R11", "hblank set", rd, 8'h41);
        pulse_line(9'd10);
        bus_read(A_STAT, rd); chk("R11", "hblank cleared", rd, 8'h01);
        autoread_done = 1'b1; tick(); autoread_done = 1'b0;
        bus_read(A_STAT, rd); chk("R11", "busy cleared", rd, 8'h00);

        // R12: general-purpose byte
        bus_write(A_GPIO, 8'h00);
        chk("R12", "no strobe on 1->0", {7'b0, latch_strobe}, 8'h00);
        bus_write(A_GPIO, 8'h80);
        chk("R12", "strobe on 0->1", {7'b0, latch_strobe}, 8'h01);
        tick();
        chk("R12", "strobe one cycle", {7'b0, latch_strobe}, 8'h00);
        bus_write(A_GPIO, 8'hC0);
        chk("R12", "no strobe on 1->1", {7'b0, latch_strobe}, 8'h00);
        bus_read(A_GPIO, rd); chk("R12", "readback", rd, 8'hC0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule